// File: doc/BRIEF.md
# Opcode-Selected 16-bit Arithmetic and Logic Unit

This block is a purely combinational arithmetic and logic unit. It takes two 16-bit unsigned operands, A and B, and a 5-bit operation code. It drives a 32-bit result and a single carry/borrow flag in the same cycle. Seventeen operations sit at fixed codes: bitwise logic, single-position shifts and rotates, add, subtract, increment, decrement, a full-width multiply and a three-way compare.

Add, subtract, increment, decrement and compare all share one ripple-carry chain of full-adder cells. An operand selector in front of the chain picks the second addend and the carry-in for each operation. The multiplier sums sixteen shifted copies of A, one for each set bit of B. A result that is only 16 bits wide is zero-extended to 32 bits. Codes with no operation assigned give zero on both outputs.

Top module: `alu16_opsel`

## Requirements
- R1: Codes 00000 (invert A), 00001 (A and B), 00010 (A or B), 00011 (not (A and B)), 00100 (not (A or B)), 00101 (A xor B) and 00110 (not (A xor B)) give the bitwise result on result[15:0]. For these codes carry_bw is 0.
- R2: Code 00111 gives A shifted left one place, and code 01000 gives A shifted right one place. The vacated bit is 0. carry_bw holds the bit that dropped out: A[15] for the left shift, A[0] for the right shift.
- R3: Code 01001 rotates A left one place, and code 01010 rotates A right one place. carry_bw holds the bit that wrapped around: A[15] for the left rotate, A[0] for the right rotate.
- R4: Code 01011 gives A+B modulo 2^16 on result[15:0]. carry_bw is the carry out of bit 15.
- R5: Code 01100 gives A−B modulo 2^16 on result[15:0]. carry_bw is 1 exactly when A < B as unsigned values.
- R6: Code 01101 gives A+1. carry_bw is 1 only when A is 0xFFFF and the result wraps to 0.
- R7: Code 01110 gives A−1. carry_bw is 1 only when A is 0 and the result wraps to 0xFFFF.
- R8: Code 01111 gives the full unsigned 32-bit product A×B on result[31:0]. carry_bw is 0.
- R9: Code 10000 compares A and B as unsigned values. result[0] is A==B, result[1] is A>B and result[2] is A<B. All other result bits are 0, and carry_bw equals result[2].
- R10: Codes 10001 through 11111 give result 0 and carry_bw 0, whatever the operands.
- R11: For every code except 01111, result[31:16] is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 16 | First operand A |
| opnd_b | input | 16 | Second operand B |
| op_sel | input | 5 | Operation code |
| result | output | 32 | Operation result, zero-extended when 16 bits wide |
| carry_bw | output | 1 | Carry, borrow or shifted-out bit |

## Verification
Within one evaluation the shared adder chain serves both the arithmetic result and the carry/borrow flag, and for compare it also yields the equality, greater and less bits. A fault in the operand selector would therefore corrupt two outputs at once. The bench provokes this with operand pairs on either side of a wrap: 0xFFFF+1, 0−1, equal operands, and A just above B with the top bit set. It judges result and carry_bw together in the same sample against values worked out from the requirements. A sweep over all 32 codes, compared with a bench-side model, also confirms that the multiplier and the unused codes never leak into each other's results.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  localparam int unsigned OPND_W = 16;
  localparam int unsigned SEL_W  = 5;
  localparam int unsigned RES_W  = 2 * OPND_W;

  typedef enum logic [SEL_W-1:0] {
    OP_INV  = 5'd0,
    OP_AND  = 5'd1,
    OP_OR   = 5'd2,
    OP_NAND = 5'd3,
    OP_NOR  = 5'd4,
    OP_XOR  = 5'd5,
    OP_XNOR = 5'd6,
    OP_SHL  = 5'd7,
    OP_SHR  = 5'd8,
    OP_ROL  = 5'd9,
    OP_ROR  = 5'd10,
    OP_ADD  = 5'd11,
    OP_SUB  = 5'd12,
    OP_INC  = 5'd13,
    OP_DEC  = 5'd14,
    OP_MUL  = 5'd15,
    OP_CMP  = 5'd16
  } alu_op_e;
endpackage

// File: rtl/alu16_fa_cell.sv
module alu16_fa_cell (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  assign s_o = x_i ^ y_i ^ c_i;
  assign c_o = (x_i & y_i) | (c_i & (x_i ^ y_i));
endmodule

// File: rtl/alu16_ripple.sv
module alu16_ripple #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic [WIDTH:0] chain;

  assign chain[0] = cin_i;

  for (genvar g = 0; g < WIDTH; g++) begin : g_cell
    alu16_fa_cell u_fa (
      .x_i (a_i[g]),
      .y_i (b_i[g]),
      .c_i (chain[g]),
      .s_o (sum_o[g]),
      .c_o (chain[g+1])
    );
  end

  assign cout_o = chain[WIDTH];

  // The cell chain must agree with plain arithmetic (R4 R5 R6 R7)
  always_comb begin
    assert_chain_sum_R4: assert ({cout_o, sum_o} ==
        ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}))
      else $error("ripple chain disagrees with arithmetic sum");
  end
endmodule

// File: rtl/alu16_shadd_mul.sv
module alu16_shadd_mul #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic [2*WIDTH-1:0] prod_o
);
  localparam int unsigned PW = 2 * WIDTH;

  logic [PW-1:0] acc [0:WIDTH];
  logic [PW-1:0] wide_mcand;

  assign wide_mcand = {{WIDTH{1'b0}}, mcand_i};
  assign acc[0]     = '0;

  for (genvar g = 0; g < WIDTH; g++) begin : g_step
    logic [PW-1:0] part;
    assign part       = mplier_i[g] ? (wide_mcand << g) : '0;
    assign acc[g+1]   = acc[g] + part;
  end

  assign prod_o = acc[WIDTH];

  always_comb begin
    assert_product_R8: assert (prod_o ==
        ({{WIDTH{1'b0}}, mcand_i} * {{WIDTH{1'b0}}, mplier_i}))
      else $error("shift-add product mismatch");
  end
endmodule

// File: rtl/alu16_opsel.sv
module alu16_opsel
  import alu16_pkg::*;
(
  input  logic [15:0] opnd_a,
  input  logic [15:0] opnd_b,
  input  logic [4:0]  op_sel,
  output logic [31:0] result,
  output logic        carry_bw
);
  localparam int unsigned W  = OPND_W;
  localparam int unsigned RW = RES_W;

  alu_op_e        op;
  logic [W-1:0]   add_b;
  logic           add_cin;
  logic [W-1:0]   add_sum;
  logic           add_cout;
  logic [RW-1:0]  mul_prod;
  logic [W-1:0]   narrow;
  logic           is_eq;
  logic           is_lt;

  assign op = alu_op_e'(op_sel);

  // Second addend and carry-in for the shared chain
  always_comb begin
    add_b   = opnd_b;
    add_cin = 1'b0;
    unique case (op)
      OP_SUB, OP_CMP: begin add_b = ~opnd_b;          add_cin = 1'b1; end
      OP_INC:         begin add_b = '0;               add_cin = 1'b1; end
      OP_DEC:         begin add_b = ~W'(1);           add_cin = 1'b1; end
      default:        begin add_b = opnd_b;           add_cin = 1'b0; end
    endcase
  end

  alu16_ripple #(.WIDTH(W)) u_add (
    .a_i    (opnd_a),
    .b_i    (add_b),
    .cin_i  (add_cin),
    .sum_o  (add_sum),
    .cout_o (add_cout)
  );

  alu16_shadd_mul #(.WIDTH(W)) u_mul (
    .mcand_i  (opnd_a),
    .mplier_i (opnd_b),
    .prod_o   (mul_prod)
  );

  assign is_lt = ~add_cout;
  assign is_eq = (add_sum == '0);

  always_comb begin
    narrow   = '0;
    carry_bw = 1'b0;
    result   = '0;
    case (op)
      OP_INV:  narrow = ~opnd_a;
      OP_AND:  narrow = opnd_a & opnd_b;
      OP_OR:   narrow = opnd_a | opnd_b;
      OP_NAND: narrow = ~(opnd_a & opnd_b);
      OP_NOR:  narrow = ~(opnd_a | opnd_b);
      OP_XOR:  narrow = opnd_a ^ opnd_b;
      OP_XNOR: narrow = ~(opnd_a ^ opnd_b);
      OP_SHL:  begin narrow = {opnd_a[W-2:0], 1'b0};      carry_bw = opnd_a[W-1]; end
      OP_SHR:  begin narrow = {1'b0, opnd_a[W-1:1]};      carry_bw = opnd_a[0];   end
      OP_ROL:  begin narrow = {opnd_a[W-2:0], opnd_a[W-1]}; carry_bw = opnd_a[W-1]; end
      OP_ROR:  begin narrow = {opnd_a[0], opnd_a[W-1:1]};   carry_bw = opnd_a[0];   end
      OP_ADD, OP_INC: begin narrow = add_sum; carry_bw = add_cout;  end
      OP_SUB, OP_DEC: begin narrow = add_sum; carry_bw = ~add_cout; end
      OP_CMP:  begin
        narrow   = {{(W-3){1'b0}}, is_lt, ~is_lt & ~is_eq, is_eq};
        carry_bw = is_lt;
      end
      default: begin narrow = '0; carry_bw = 1'b0; end
    endcase
    if (op == OP_MUL) result = mul_prod;
    else              result = {{(RW-W){1'b0}}, narrow};
  end

  // Guards next to the output selection
  always_comb begin
    if (op_sel > 5'd16) begin
      assert_unused_zero_R10: assert (result == '0 && !carry_bw)
        else $error("unused code produced nonzero output");
    end
    if (op_sel != 5'd15) begin
      assert_upper_clear_R11: assert (result[RW-1:W] == '0)
        else $error("upper half set on narrow operation");
    end
    if (op_sel == 5'd16) begin
      assert_cmp_onehot_R9: assert ($countones(result[2:0]) == 1 &&
                                    result[RW-1:3] == '0 && carry_bw == result[2])
        else $error("compare flags malformed");
    end
    if (op_sel == 5'd15) begin
      assert_mul_nocarry_R8: assert (!carry_bw)
        else $error("multiply raised carry");
    end
  end
endmodule

// File: tb/tb_alu16_opsel.sv
module tb_alu16_opsel;
  typedef struct packed {
    logic [4:0]  op;
    logic [15:0] a;
    logic [15:0] b;
    logic [31:0] res;
    logic        c;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 29;
  localparam vec_t VECS [NVEC] = '{
    '{5'h00, 16'h00F0, 16'h0000, 32'h0000FF0F, 1'b0, 8'd1},  // R1 invert
    '{5'h01, 16'hF0F0, 16'hFF00, 32'h0000F000, 1'b0, 8'd1},  // R1 and
    '{5'h02, 16'hF0F0, 16'h0F0F, 32'h0000FFFF, 1'b0, 8'd1},  // R1 or
    '{5'h03, 16'hFFFF, 16'h00FF, 32'h0000FF00, 1'b0, 8'd1},  // R1 nand
    '{5'h04, 16'hF000, 16'h0F00, 32'h000000FF, 1'b0, 8'd1},  // R1 nor
    '{5'h05, 16'hAAAA, 16'hFFFF, 32'h00005555, 1'b0, 8'd1},  // R1 xor
    '{5'h06, 16'h1234, 16'h1234, 32'h0000FFFF, 1'b0, 8'd1},  // R1 xnor
    '{5'h07, 16'h8001, 16'h0000, 32'h00000002, 1'b1, 8'd2},  // R2 shl
    '{5'h08, 16'h8001, 16'h0000, 32'h00004000, 1'b1, 8'd2},  // R2 shr
    '{5'h09, 16'h8001, 16'h0000, 32'h00000003, 1'b1, 8'd3},  // R3 rol
    '{5'h0A, 16'h8001, 16'h0000, 32'h0000C000, 1'b1, 8'd3},  // R3 ror
    '{5'h0A, 16'h0002, 16'h0000, 32'h00000001, 1'b0, 8'd3},  // R3 ror no wrap
    '{5'h0B, 16'hFFFF, 16'h0001, 32'h00000000, 1'b1, 8'd4},  // R4 carry out
    '{5'h0B, 16'h1234, 16'h4321, 32'h00005555, 1'b0, 8'd4},  // R4
    '{5'h0C, 16'h0005, 16'h0007, 32'h0000FFFE, 1'b1, 8'd5},  // R5 borrow
    '{5'h0C, 16'h0007, 16'h0005, 32'h00000002, 1'b0, 8'd5},  // R5
    '{5'h0C, 16'h0005, 16'h0005, 32'h00000000, 1'b0, 8'd5},  // R5 equal
    '{5'h0D, 16'hFFFF, 16'h1234, 32'h00000000, 1'b1, 8'd6},  // R6 wrap
    '{5'h0D, 16'h0010, 16'h0000, 32'h00000011, 1'b0, 8'd6},  // R6
    '{5'h0E, 16'h0000, 16'hFFFF, 32'h0000FFFF, 1'b1, 8'd7},  // R7 wrap
    '{5'h0E, 16'h0010, 16'h0000, 32'h0000000F, 1'b0, 8'd7},  // R7
    '{5'h0F, 16'hFFFF, 16'hFFFF, 32'hFFFE0001, 1'b0, 8'd8},  // R8 max
    '{5'h0F, 16'h0003, 16'h0005, 32'h0000000F, 1'b0, 8'd8},  // R8
    '{5'h10, 16'h0005, 16'h0005, 32'h00000001, 1'b0, 8'd9},  // R9 equal
    '{5'h10, 16'h0009, 16'h0005, 32'h00000002, 1'b0, 8'd9},  // R9 greater
    '{5'h10, 16'h0005, 16'h0009, 32'h00000004, 1'b1, 8'd9},  // R9 less
    '{5'h10, 16'h8000, 16'h7FFF, 32'h00000002, 1'b0, 8'd9},  // R9 unsigned
    '{5'h11, 16'hFFFF, 16'hFFFF, 32'h00000000, 1'b0, 8'd10}, // R10
    '{5'h1F, 16'hFFFF, 16'hFFFF, 32'h00000000, 1'b0, 8'd10}  // R10
  };

  logic        clk = 1'b0;
  logic [15:0] opnd_a = '0;
  logic [15:0] opnd_b = '0;
  logic [4:0]  op_sel = '0;
  logic [31:0] result;
  logic        carry_bw;
  int          n_run  = 0;
  int          n_fail = 0;
  bit          done   = 1'b0;

  always #4 clk = ~clk;

  alu16_opsel dut (
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .op_sel   (op_sel),
    .result   (result),
    .carry_bw (carry_bw)
  );

  function automatic logic [32:0] model(input logic [4:0] op,
                                        input logic [15:0] a,
                                        input logic [15:0] b);
    logic [31:0] r;
    logic        c;
    logic [16:0] t;
    r = '0; c = 1'b0;
    case (op)
      5'd0:  r = {16'd0, ~a};
      5'd1:  r = {16'd0, a & b};
      5'd2:  r = {16'd0, a | b};
      5'd3:  r = {16'd0, ~(a & b)};
      5'd4:  r = {16'd0, ~(a | b)};
      5'd5:  r = {16'd0, a ^ b};
      5'd6:  r = {16'd0, ~(a ^ b)};
      5'd7:  begin r = {16'd0, a << 1}; c = a[15]; end
      5'd8:  begin r = {16'd0, a >> 1}; c = a[0];  end
      5'd9:  begin r = {16'd0, a[14:0], a[15]}; c = a[15]; end
      5'd10: begin r = {16'd0, a[0], a[15:1]};  c = a[0];  end
      5'd11: begin t = {1'b0, a} + {1'b0, b}; r = {16'd0, t[15:0]}; c = t[16]; end
      5'd12: begin r = {16'd0, a - b}; c = (a < b); end
      5'd13: begin r = {16'd0, a + 16'd1}; c = (a == 16'hFFFF); end
      5'd14: begin r = {16'd0, a - 16'd1}; c = (a == 16'h0000); end
      5'd15: r = {16'd0, a} * {16'd0, b};
      5'd16: begin r = {29'd0, a < b, a > b, a == b}; c = (a < b); end
      default: begin r = '0; c = 1'b0; end
    endcase
    return {c, r};
  endfunction

  task automatic apply_check(input logic [4:0] op, input logic [15:0] a,
                             input logic [15:0] b, input logic [31:0] er,
                             input logic ec, input int req);
    @(posedge clk);
    op_sel = op; opnd_a = a; opnd_b = b;
    @(negedge clk);
    n_run++;
    if (result !== er || carry_bw !== ec) begin
      n_fail++;
      $display("FAIL R%0d op=%05b a=%04h b=%04h: got res=%08h c=%0b, expected res=%08h c=%0b",
               req, op, a, b, result, carry_bw, er, ec);
    end
  endtask

  initial begin : watchdog
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [32:0] exp;
    logic [15:0] pa [8];
    logic [15:0] pb [8];
    // Initial state: all inputs zero, code 00000 inverts A (R1, R11)
    apply_check(5'd0, 16'h0000, 16'h0000, 32'h0000FFFF, 1'b0, 1);

    for (int i = 0; i < NVEC; i++) begin
      apply_check(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].res, VECS[i].c,
                  int'(VECS[i].req));
    end

    // Corner pairs around wraps, equality and the top bit; every code (R11 sweep)
    pa = '{16'h0000, 16'hFFFF, 16'h8000, 16'h7FFF, 16'h0001, 16'hA5A5, 16'h1234, 16'hFFFE};
    pb = '{16'h0000, 16'hFFFF, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h5A5A, 16'h1234, 16'h0002};
    for (int op = 0; op < 32; op++) begin
      for (int k = 0; k < 8; k++) begin
        exp = model(5'(op), pa[k], pb[k]);
        // R11 upper half zero except multiply; R10 for codes above 16
        apply_check(5'(op), pa[k], pb[k], exp[31:0], exp[32],
                    (op > 16) ? 10 : ((op == 15) ? 8 : 11));
      end
    end

    // Unused code with operand change: output must stay zero (R10)
    apply_check(5'd20, 16'h1357, 16'h2468, 32'h0, 1'b0, 10);
    // Multiply by zero and by one (R8)
    apply_check(5'd15, 16'hBEEF, 16'h0000, 32'h0, 1'b0, 8);
    apply_check(5'd15, 16'hBEEF, 16'h0001, 32'h0000BEEF, 1'b0, 8);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule